// File: doc/BRIEF.md
# Integer Execute Stage for a Small 32-bit RISC Subset

This block is the purely combinational execute step of a simple in-order integer pipeline. It receives the already separated fields of one instruction and the two source register values read from the register file. The fields are the primary opcode, the function code, the fixed shift amount, the two candidate destination indices and the 16-bit immediate. In the same cycle it returns the value to write back, the destination index and a write strobe. For word loads and stores it also returns the effective address and a request flag.

The unit covers these operations:
- wrapping add and subtract;
- bitwise AND, OR and XOR;
- logical left and right shifts, by a constant or by a register;
- signed and unsigned less-than compares;
- load-upper-immediate.

Register-format and immediate-format variants are both handled. The immediate is sign-extended for the add, the signed compare and the address add. It is zero-extended for the bitwise ops and the unsigned compare. Register storage, data memory, multiply and branch logic live elsewhere. Arithmetic overflow never traps.

Top module: `exu_core`

## Requirements
- R1: With `op_code` 0, funct 33 writes `rs_val + rt_val` and funct 35 writes `rs_val - rt_val`, both modulo 2^32, to index `rd_idx`.
- R2: With `op_code` 0, funct 36, 37 and 38 write the bitwise AND, OR and XOR of `rs_val` and `rt_val` to `rd_idx`.
- R3: With `op_code` 0, funct 0 shifts `rt_val` left and funct 2 shifts it right by `sh_amt`, filling vacated bits with zero, result to `rd_idx`.
- R4: With `op_code` 0, funct 4 and 6 shift `rt_val` left and right (zero fill) by the low 5 bits of `rs_val` only, result to `rd_idx`.
- R5: With `op_code` 0, funct 42 writes 1 when `rs_val` < `rt_val` as signed numbers and funct 43 as unsigned numbers, else 0.
- R6: Opcode 9 writes `rs_val` plus the sign-extended immediate to index `rt_idx`.
- R7: Opcodes 12, 13 and 14 write the AND, OR and XOR of `rs_val` with the zero-extended immediate to `rt_idx`.
- R8: Opcode 10 writes 1 when `rs_val` is signed-less than the sign-extended immediate. Opcode 11 writes 1 when `rs_val` is unsigned-less than the zero-extended immediate. Both write 0 otherwise, to `rt_idx`.
- R9: Opcode 15 writes the immediate into bits 31:16 with bits 15:0 cleared, to `rt_idx`.
- R10: Opcode 35 raises `ld_req` and opcode 43 raises `st_req`. Each drives `mem_addr` = `rs_val` + sign-extended immediate and keeps `wb_en` low. A load reports `rt_idx` on `wb_idx`.
- R11: `wb_en` is never high when the destination index is 0, so register 0 stays zero.
- R12: Any opcode outside {0, 9..15, 35, 43}, or opcode 0 with a funct outside {0, 2, 4, 6, 33, 35..38, 42, 43}, raises `illegal` and holds `wb_en`, `ld_req` and `st_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | primary opcode |
| fn_code | input | 6 | function code for register format |
| sh_amt | input | 5 | constant shift amount |
| rd_idx | input | 5 | destination index for register format |
| rt_idx | input | 5 | second source / destination index for immediate format |
| imm_val | input | 16 | immediate field |
| rs_val | input | 32 | first source operand value |
| rt_val | input | 32 | second source operand value |
| wb_data | output | 32 | result to write back |
| wb_idx | output | 5 | destination register index |
| wb_en | output | 1 | register write strobe |
| mem_addr | output | 32 | effective address for loads and stores |
| ld_req | output | 1 | word load requested |
| st_req | output | 1 | word store requested |
| illegal | output | 1 | unrecognised opcode or function code |

## Verification
The bench builds two copies at the default 32-bit width. One uses the log-stage barrel shifter and the other the plain shift operator, so both shifter variants face the same vectors. Random vectors biased towards the extreme operand values reach the signed/unsigned compare boundaries and add wrap-around. They also reach shift amounts of 0 and 31 and register-held shift amounts above 31. Random vectors also include illegal codes. Directed vectors pin the immediate extension rules at 0x8000 and 0xFFFF and the register-0 write guard.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int IMM_W = 16;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_ADDIU = 6'd9;
  localparam logic [5:0] OPC_SLTI  = 6'd10;
  localparam logic [5:0] OPC_SLTIU = 6'd11;
  localparam logic [5:0] OPC_ANDI  = 6'd12;
  localparam logic [5:0] OPC_ORI   = 6'd13;
  localparam logic [5:0] OPC_XORI  = 6'd14;
  localparam logic [5:0] OPC_LUI   = 6'd15;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SW    = 6'd43;

  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SLLV = 6'd4;
  localparam logic [5:0] FN_SRLV = 6'd6;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SHL, ALU_SHR, ALU_LTS, ALU_LTU, ALU_UPPER
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_REG, OPB_SEXT, OPB_ZEXT
  } opb_sel_e;

  typedef struct packed {
    logic     legal;
    alu_op_e  op;
    opb_sel_e opb;
    logic     sh_var;
    logic     dst_rd;
    logic     wr;
    logic     ld;
    logic     st;
    logic     cmp;
  } ctrl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.legal  = 1'b1;
    ctrl.op     = ALU_ADD;
    ctrl.opb    = OPB_REG;
    ctrl.sh_var = 1'b0;
    ctrl.dst_rd = 1'b0;
    ctrl.wr     = 1'b1;
    ctrl.ld     = 1'b0;
    ctrl.st     = 1'b0;
    ctrl.cmp    = 1'b0;
    if (op_code == OPC_RTYPE) begin
      ctrl.dst_rd = 1'b1;
      unique case (fn_code)
        FN_ADDU: ctrl.op = ALU_ADD;
        FN_SUBU: ctrl.op = ALU_SUB;
        FN_AND:  ctrl.op = ALU_AND;
        FN_OR:   ctrl.op = ALU_OR;
        FN_XOR:  ctrl.op = ALU_XOR;
        FN_SLL:  ctrl.op = ALU_SHL;
        FN_SRL:  ctrl.op = ALU_SHR;
        FN_SLLV: begin ctrl.op = ALU_SHL; ctrl.sh_var = 1'b1; end
        FN_SRLV: begin ctrl.op = ALU_SHR; ctrl.sh_var = 1'b1; end
        FN_SLT:  begin ctrl.op = ALU_LTS; ctrl.cmp = 1'b1; end
        FN_SLTU: begin ctrl.op = ALU_LTU; ctrl.cmp = 1'b1; end
        default: begin ctrl.legal = 1'b0; ctrl.wr = 1'b0; end
      endcase
    end else begin
      unique case (op_code)
        OPC_ADDIU: begin ctrl.op = ALU_ADD;   ctrl.opb = OPB_SEXT; end
        OPC_SLTI:  begin ctrl.op = ALU_LTS;   ctrl.opb = OPB_SEXT; ctrl.cmp = 1'b1; end
        OPC_SLTIU: begin ctrl.op = ALU_LTU;   ctrl.opb = OPB_ZEXT; ctrl.cmp = 1'b1; end
        OPC_ANDI:  begin ctrl.op = ALU_AND;   ctrl.opb = OPB_ZEXT; end
        OPC_ORI:   begin ctrl.op = ALU_OR;    ctrl.opb = OPB_ZEXT; end
        OPC_XORI:  begin ctrl.op = ALU_XOR;   ctrl.opb = OPB_ZEXT; end
        OPC_LUI:   begin ctrl.op = ALU_UPPER; ctrl.opb = OPB_SEXT; end
        OPC_LW:    begin ctrl.opb = OPB_SEXT; ctrl.wr = 1'b0; ctrl.ld = 1'b1; end
        OPC_SW:    begin ctrl.opb = OPB_SEXT; ctrl.wr = 1'b0; ctrl.st = 1'b1; end
        default:   begin ctrl.legal = 1'b0;   ctrl.wr = 1'b0; end
      endcase
    end
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter bit BARREL_SHIFT = 1'b1,
  localparam int SHW         = $clog2(XLEN)
) (
  input  alu_op_e             op,
  input  logic [XLEN-1:0]     opa,
  input  logic [XLEN-1:0]     opb,
  input  logic [SHW-1:0]      shamt,
  output logic [XLEN-1:0]     res
);

  localparam int UPPER_POS = IMM_W;

  function automatic logic [XLEN-1:0] f_lt_signed(input logic [XLEN-1:0] x,
                                                  input logic [XLEN-1:0] y);
    logic [XLEN-1:0] r;
    r    = '0;
    r[0] = (x[XLEN-1] != y[XLEN-1]) ? x[XLEN-1] : (x < y);
    return r;
  endfunction

  function automatic logic [XLEN-1:0] f_lt_unsigned(input logic [XLEN-1:0] x,
                                                    input logic [XLEN-1:0] y);
    logic [XLEN-1:0] r;
    r    = '0;
    r[0] = (x < y);
    return r;
  endfunction

  logic [XLEN-1:0] shl_res;
  logic [XLEN-1:0] shr_res;

  generate
    if (BARREL_SHIFT) begin : g_barrel
      logic [XLEN-1:0] lstage [SHW+1];
      logic [XLEN-1:0] rstage [SHW+1];
      assign lstage[0] = opb;
      assign rstage[0] = opb;
      for (genvar i = 0; i < SHW; i++) begin : g_stage
        assign lstage[i+1] = shamt[i] ? (lstage[i] << (2**i)) : lstage[i];
        assign rstage[i+1] = shamt[i] ? (rstage[i] >> (2**i)) : rstage[i];
      end
      assign shl_res = lstage[SHW];
      assign shr_res = rstage[SHW];
    end else begin : g_operator
      assign shl_res = opb << shamt;
      assign shr_res = opb >> shamt;
    end
  endgenerate

  always_comb begin
    unique case (op)
      ALU_ADD:   res = opa + opb;
      ALU_SUB:   res = opa - opb;
      ALU_AND:   res = opa & opb;
      ALU_OR:    res = opa | opb;
      ALU_XOR:   res = opa ^ opb;
      ALU_SHL:   res = shl_res;
      ALU_SHR:   res = shr_res;
      ALU_LTS:   res = f_lt_signed(opa, opb);
      ALU_LTU:   res = f_lt_unsigned(opa, opb);
      ALU_UPPER: res = opb << UPPER_POS;
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/exu_agu.sv
module exu_agu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] addr
);

  function automatic logic [XLEN-1:0] f_ea(input logic [XLEN-1:0] b,
                                           input logic [XLEN-1:0] o);
    return b + o;
  endfunction

  assign addr = f_ea(base, offset);

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int REGW         = 5,
  parameter bit BARREL_SHIFT = 1'b1,
  localparam int SHW         = $clog2(XLEN)
) (
  input  logic [5:0]       op_code,
  input  logic [5:0]       fn_code,
  input  logic [SHW-1:0]   sh_amt,
  input  logic [REGW-1:0]  rd_idx,
  input  logic [REGW-1:0]  rt_idx,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  wb_data,
  output logic [REGW-1:0]  wb_idx,
  output logic             wb_en,
  output logic [XLEN-1:0]  mem_addr,
  output logic             ld_req,
  output logic             st_req,
  output logic             illegal
);

  localparam int EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{EXT_W{1'b0}}, v};
  endfunction

  ctrl_t           ctrl;
  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] imm_zext;
  logic [XLEN-1:0] operand_b;
  logic [SHW-1:0]  shift_by;
  logic [XLEN-1:0] alu_res;
  logic [REGW-1:0] dst_sel;
  logic            dst_is_zero;
  logic            is_compare;

  exu_decode u_dec (
    .op_code (op_code),
    .fn_code (fn_code),
    .ctrl    (ctrl)
  );

  assign imm_sext = f_sext(imm_val);
  assign imm_zext = f_zext(imm_val);

  always_comb begin
    unique case (ctrl.opb)
      OPB_SEXT: operand_b = imm_sext;
      OPB_ZEXT: operand_b = imm_zext;
      default:  operand_b = rt_val;
    endcase
  end

  assign shift_by = ctrl.sh_var ? rs_val[SHW-1:0] : sh_amt;

  exu_alu #(
    .XLEN         (XLEN),
    .BARREL_SHIFT (BARREL_SHIFT)
  ) u_alu (
    .op    (ctrl.op),
    .opa   (rs_val),
    .opb   (operand_b),
    .shamt (shift_by),
    .res   (alu_res)
  );

  exu_agu #(
    .XLEN (XLEN)
  ) u_agu (
    .base   (rs_val),
    .offset (imm_sext),
    .addr   (mem_addr)
  );

  assign dst_sel     = ctrl.dst_rd ? rd_idx : rt_idx;
  assign dst_is_zero = (dst_sel == '0);
  assign is_compare  = ctrl.cmp;

  assign illegal = ~ctrl.legal;
  assign wb_data = alu_res;
  assign wb_idx  = ctrl.legal ? dst_sel : '0;
  assign wb_en   = ctrl.legal & ctrl.wr & ~dst_is_zero;
  assign ld_req  = ctrl.legal & ctrl.ld;
  assign st_req  = ctrl.legal & ctrl.st;

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
  parameter int XLEN = 32,
  parameter int REGW = 5
) (
  input logic [5:0]      op_code,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] imm_sext,
  input logic [XLEN-1:0] alu_res,
  input logic            is_compare,
  input logic [XLEN-1:0] wb_data,
  input logic [REGW-1:0] wb_idx,
  input logic            wb_en,
  input logic [XLEN-1:0] mem_addr,
  input logic            ld_req,
  input logic            st_req,
  input logic            illegal
);

  always_comb begin
    if (wb_en) begin
      assert_reg0_write_blocked_R11 : assert (wb_idx != '0);
    end
    if (illegal) begin
      assert_illegal_is_quiet_R12 : assert (!wb_en && !ld_req && !st_req);
    end
    assert_single_action_R10 : assert ($onehot0({wb_en, ld_req, st_req}));
    if (is_compare && !illegal) begin
      assert_compare_single_bit_R5 : assert (alu_res[XLEN-1:1] == '0);
    end
    if (op_code == 6'd15 && !illegal) begin
      assert_upper_low_half_clear_R9 : assert (wb_data[15:0] == 16'h0);
    end
    if (ld_req || st_req) begin
      assert_effective_address_R10 : assert (mem_addr == rs_val + imm_sext);
    end
  end

endmodule

bind exu_core exu_core_chk #(
  .XLEN (XLEN),
  .REGW (REGW)
) u_chk (
  .op_code    (op_code),
  .rs_val     (rs_val),
  .imm_sext   (imm_sext),
  .alu_res    (alu_res),
  .is_compare (is_compare),
  .wb_data    (wb_data),
  .wb_idx     (wb_idx),
  .wb_en      (wb_en),
  .mem_addr   (mem_addr),
  .ld_req     (ld_req),
  .st_req     (st_req),
  .illegal    (illegal)
);

// File: tb/exu_core_tb.sv
module exu_core_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0]  op_code, fn_code;
  logic [4:0]  sh_amt, rd_idx, rt_idx;
  logic [15:0] imm_val;
  logic [31:0] rs_val, rt_val;

  logic [31:0] d0_data, d0_addr, d1_data, d1_addr;
  logic [4:0]  d0_idx, d1_idx;
  logic        d0_wen, d0_ld, d0_st, d0_ill;
  logic        d1_wen, d1_ld, d1_st, d1_ill;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  exu_core #(.XLEN(32), .REGW(5), .BARREL_SHIFT(1'b1)) u_dut (
    .op_code(op_code), .fn_code(fn_code), .sh_amt(sh_amt), .rd_idx(rd_idx),
    .rt_idx(rt_idx), .imm_val(imm_val), .rs_val(rs_val), .rt_val(rt_val),
    .wb_data(d0_data), .wb_idx(d0_idx), .wb_en(d0_wen), .mem_addr(d0_addr),
    .ld_req(d0_ld), .st_req(d0_st), .illegal(d0_ill));

  exu_core #(.XLEN(32), .REGW(5), .BARREL_SHIFT(1'b0)) u_dut_op (
    .op_code(op_code), .fn_code(fn_code), .sh_amt(sh_amt), .rd_idx(rd_idx),
    .rt_idx(rt_idx), .imm_val(imm_val), .rs_val(rs_val), .rt_val(rt_val),
    .wb_data(d1_data), .wb_idx(d1_idx), .wb_en(d1_wen), .mem_addr(d1_addr),
    .ld_req(d1_ld), .st_req(d1_st), .illegal(d1_ill));

  // Independent reference model built from the requirement list.
  task automatic model(output logic [31:0] e_data, output logic [4:0] e_idx,
                       output logic e_wen, output logic [31:0] e_addr,
                       output logic e_ld, output logic e_st, output logic e_ill,
                       output string tag);
    logic [31:0] se, ze;
    se = 32'(signed'(imm_val));
    ze = {16'h0, imm_val};
    e_data = '0; e_idx = rt_idx; e_ld = 0; e_st = 0; e_ill = 0;
    e_addr = rs_val + se; tag = "R12";
    if (op_code == 6'd0) begin
      e_idx = rd_idx;
      case (fn_code)
        6'd33: begin e_data = rs_val + rt_val; tag = "R1"; end
        6'd35: begin e_data = rs_val - rt_val; tag = "R1"; end
        6'd36: begin e_data = rs_val & rt_val; tag = "R2"; end
        6'd37: begin e_data = rs_val | rt_val; tag = "R2"; end
        6'd38: begin e_data = rs_val ^ rt_val; tag = "R2"; end
        6'd0:  begin e_data = rt_val << sh_amt; tag = "R3"; end
        6'd2:  begin e_data = rt_val >> sh_amt; tag = "R3"; end
        6'd4:  begin e_data = rt_val << rs_val[4:0]; tag = "R4"; end
        6'd6:  begin e_data = rt_val >> rs_val[4:0]; tag = "R4"; end
        6'd42: begin e_data = {31'h0, $signed(rs_val) < $signed(rt_val)}; tag = "R5"; end
        6'd43: begin e_data = {31'h0, rs_val < rt_val}; tag = "R5"; end
        default: e_ill = 1;
      endcase
    end else begin
      case (op_code)
        6'd9:  begin e_data = rs_val + se; tag = "R6"; end
        6'd10: begin e_data = {31'h0, $signed(rs_val) < $signed(se)}; tag = "R8"; end
        6'd11: begin e_data = {31'h0, rs_val < ze}; tag = "R8"; end
        6'd12: begin e_data = rs_val & ze; tag = "R7"; end
        6'd13: begin e_data = rs_val | ze; tag = "R7"; end
        6'd14: begin e_data = rs_val ^ ze; tag = "R7"; end
        6'd15: begin e_data = {imm_val, 16'h0}; tag = "R9"; end
        6'd35: begin e_ld = 1; tag = "R10"; end
        6'd43: begin e_st = 1; tag = "R10"; end
        default: e_ill = 1;
      endcase
    end
    e_wen = !e_ill && !e_ld && !e_st && (e_idx != 5'd0);
    if (e_idx == 5'd0 && !e_ill && !e_ld && !e_st) tag = {tag, "/R11"};
  endtask

  task automatic compare_one(input string who, input logic [31:0] a_data,
                             input logic [4:0] a_idx, input logic a_wen,
                             input logic [31:0] a_addr, input logic a_ld,
                             input logic a_st, input logic a_ill);
    logic [31:0] e_data, e_addr;
    logic [4:0]  e_idx;
    logic        e_wen, e_ld, e_st, e_ill;
    string       tag;
    bit          bad;
    model(e_data, e_idx, e_wen, e_addr, e_ld, e_st, e_ill, tag);
    bad = (a_ill != e_ill) || (a_wen != e_wen) || (a_ld != e_ld) || (a_st != e_st);
    if (e_wen && (a_data != e_data || a_idx != e_idx)) bad = 1;
    if ((e_ld || e_st) && a_addr != e_addr) bad = 1;
    if (e_ld && a_idx != e_idx) bad = 1;
    n_checks++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s %s op=%0d fn=%0d: got data=%h idx=%0d wen=%b addr=%h ld=%b st=%b ill=%b exp data=%h idx=%0d wen=%b addr=%h ld=%b st=%b ill=%b",
               tag, who, op_code, fn_code, a_data, a_idx, a_wen, a_addr, a_ld, a_st, a_ill,
               e_data, e_idx, e_wen, e_addr, e_ld, e_st, e_ill);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
                       input logic [4:0] rd, input logic [4:0] rt, input logic [15:0] imm,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_code = op; fn_code = fn; sh_amt = sh; rd_idx = rd; rt_idx = rt;
    imm_val = imm; rs_val = a; rt_val = b;
    #2;
    compare_one("barrel", d0_data, d0_idx, d0_wen, d0_addr, d0_ld, d0_st, d0_ill);
    compare_one("operator", d1_data, d1_idx, d1_wen, d1_addr, d1_ld, d1_st, d1_ill);
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'h8000_0000;
      3: return 32'hffff_ffff;
      4: return 32'h0000_0001 + ($urandom % 40);
      default: return $urandom;
    endcase
  endfunction

  localparam logic [5:0] RFN [11] = '{6'd33, 6'd35, 6'd36, 6'd37, 6'd38,
                                      6'd0, 6'd2, 6'd4, 6'd6, 6'd42, 6'd43};
  localparam logic [5:0] IOP [9]  = '{6'd9, 6'd10, 6'd11, 6'd12, 6'd13,
                                      6'd14, 6'd15, 6'd35, 6'd43};

  initial begin
    op_code = '0; fn_code = '0; sh_amt = '0; rd_idx = '0; rt_idx = '0;
    imm_val = '0; rs_val = '0; rt_val = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: all-zero fields decode to a shift into register 0 (R11)
    @(negedge clk); #2;
    n_checks++;
    if (d0_wen || d0_ill || d0_ld || d0_st) begin
      n_fail++;
      $display("FAIL R11 idle: wen=%b ill=%b ld=%b st=%b exp 0 0 0 0", d0_wen, d0_ill, d0_ld, d0_st);
    end

    // Directed corners
    apply(6'd0, 6'd33, 5'd0, 5'd3, 5'd0, 16'h0, 32'hffff_ffff, 32'h2);        // R1 wrap
    apply(6'd0, 6'd35, 5'd0, 5'd4, 5'd0, 16'h0, 32'h0, 32'h1);                // R1 borrow
    apply(6'd0, 6'd38, 5'd0, 5'd5, 5'd0, 16'h0, 32'hf0f0_f0f0, 32'hff00_ff00); // R2
    apply(6'd0, 6'd2, 5'd31, 5'd6, 5'd0, 16'h0, 32'h0, 32'h8000_0000);        // R3 zero fill
    apply(6'd0, 6'd0, 5'd31, 5'd6, 5'd0, 16'h0, 32'h0, 32'h0000_0003);        // R3
    apply(6'd0, 6'd4, 5'd0, 5'd7, 5'd0, 16'h0, 32'd33, 32'h1);                // R4 low bits
    apply(6'd0, 6'd6, 5'd0, 5'd7, 5'd0, 16'h0, 32'hffff_ffe4, 32'h8000_0000); // R4
    apply(6'd0, 6'd42, 5'd0, 5'd8, 5'd0, 16'h0, 32'h8000_0000, 32'h1);        // R5 signed
    apply(6'd0, 6'd43, 5'd0, 5'd8, 5'd0, 16'h0, 32'h8000_0000, 32'h1);        // R5 unsigned
    apply(6'd9, 6'd0, 5'd0, 5'd0, 5'd9, 16'hfffe, 32'h1, 32'h0);              // R6
    apply(6'd12, 6'd0, 5'd0, 5'd0, 5'd9, 16'hffff, 32'hffff_ffff, 32'h0);     // R7
    apply(6'd13, 6'd0, 5'd0, 5'd0, 5'd9, 16'h8000, 32'h0, 32'h0);             // R7
    apply(6'd10, 6'd0, 5'd0, 5'd0, 5'd10, 16'h8000, 32'hffff_ffff, 32'h0);    // R8
    apply(6'd11, 6'd0, 5'd0, 5'd0, 5'd10, 16'h8000, 32'h0000_0005, 32'h0);    // R8
    apply(6'd11, 6'd0, 5'd0, 5'd0, 5'd10, 16'h8000, 32'h0000_9000, 32'h0);    // R8
    apply(6'd15, 6'd0, 5'd0, 5'd0, 5'd11, 16'h8001, 32'hffff_ffff, 32'h0);    // R9
    apply(6'd35, 6'd0, 5'd0, 5'd0, 5'd12, 16'hfffc, 32'h100, 32'h0);          // R10 load
    apply(6'd43, 6'd0, 5'd0, 5'd0, 5'd12, 16'h0010, 32'h200, 32'h0);          // R10 store
    apply(6'd9, 6'd0, 5'd0, 5'd0, 5'd0, 16'h1234, 32'h5, 32'h0);              // R11
    apply(6'd0, 6'd33, 5'd0, 5'd0, 5'd1, 16'h0, 32'h5, 32'h6);                // R11
    apply(6'd63, 6'd0, 5'd0, 5'd0, 5'd1, 16'h0, 32'h5, 32'h6);                // R12 op
    apply(6'd0, 6'd1, 5'd0, 5'd3, 5'd1, 16'h0, 32'h5, 32'h6);                 // R12 funct

    // Constrained random mix
    for (int k = 0; k < 3000; k++) begin
      logic [5:0] op, fn;
      int sel;
      sel = $urandom % 24;
      fn  = 6'($urandom);
      if (sel < 11) begin op = 6'd0; fn = RFN[sel]; end
      else if (sel < 20) op = IOP[sel-11];
      else if (sel < 22) begin op = 6'd0; end
      else op = 6'($urandom);
      apply(op, fn, 5'($urandom), 5'($urandom), 5'($urandom),
            16'($urandom), pick_val(), pick_val());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule